// File: doc/BRIEF.md
# In-Order Retirement Buffer with Squash Walk

This block keeps the in-flight instructions of an out-of-order core in a circular buffer, in program order, and retires them from the oldest end. Rename writes entries in at the tail, each carrying a sequence number. Execute reports completions by sequence number. Each cycle the block retires up to a fixed number of finished entries from the head. Every cycle a backward status bus returns the last retired sequence number, the free-entry count and any request to execute a non-speculative instruction now at the head.

A misprediction or other redirect arrives as a squash request carrying the sequence number of the last surviving instruction. The block then spends several cycles walking backward from the tail. The walk flags every younger entry as squashed, and it blocks both insertion and retirement while it runs. Squashed entries stay in the buffer until they reach the head. There they leave silently and do not use retirement bandwidth. The redirect information that came with the request is held on the backward bus for the consumer stages.

A head entry that is ready but not executed and is marked non-speculative raises an execute request and stops retirement for that cycle. A retiring entry that carries a fault raises a trap pulse.

Top module: `rob_retire`

## Requirements
- R1: While reset is held and directly after it, the buffer is empty: `bk_free` equals DEPTH (16), no `ret_valid` bit is set, `bk_squashing` is low and `commit_total` is 0.
- R2: Insertion takes the valid lanes that are not flagged squashed, at most RENAME_W (2) per cycle, and places them in lane order. Lanes flagged squashed are dropped. `ins_accept` is high, and the lanes are taken, only when no squash is in progress, no squash request is present and `bk_free` is at least the number of kept lanes.
- R3: A completion mark makes the matching entry ready. Retirement takes ready entries from the head in program order, at most COMMIT_W (2) per cycle. It stops at the first entry that is not ready. Slot 0 of `ret_seq` holds the oldest retired entry.
- R4: A squashed entry at the head is removed without setting any `ret_valid` bit and does not count toward the per-cycle limit. The scan window from the head is 2*COMMIT_W entries.
- R5: A non-executed, non-speculative entry at the head drives `bk_ns_valid` with its sequence number on `bk_ns_seq`. Retirement stops for that cycle. The request is not repeated until a completion mark for that entry arrives, and the entry then retires.
- R6: An entry whose completion carried `cmp_fault` raises `ret_trap` in the cycle it retires. Retirement stops after it in that cycle.
- R7: A squash request wins over insertion and retirement in its own cycle. In the next cycle `bk_squash` pulses for one cycle, `bk_squashing` rises, and `bk_done_seq` shows the squash sequence number. The mispredict and taken flags and both PCs from the request appear on the `bk_` outputs.
- R8: The walk flags, from the tail backward, up to SQUASH_W (2) entries per cycle whose sequence numbers are younger than the squash point. Age uses wraparound-safe comparison: the difference taken modulo 2^SEQ_W is positive. After the pulse cycle, `bk_done_seq` shows the sequence number of the next entry to examine. `bk_squashing` falls after a cycle that flags fewer than SQUASH_W entries.
- R9: Completion marks take effect during the walk as well.
- R10: `bk_free` equals DEPTH minus the occupancy every cycle.
- R11: In a cycle with retirements, `bk_done_seq` shows the youngest sequence number retired in that cycle. Outside a walk, when nothing retires, it holds its last value.
- R12: `commit_total` increases by the number of set `ret_valid` bits in each cycle. Retirement never takes place from an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | RENAME_W | Lane carries an instruction from rename |
| ins_seq | input | RENAME_W x SEQ_W | Sequence number per lane |
| ins_squashed | input | RENAME_W | Lane already squashed; drop it |
| ins_nonspec | input | RENAME_W | Lane must execute only at the head |
| ins_accept | output | 1 | Lanes taken this cycle |
| cmp_valid | input | CMPL_W | Completion mark valid |
| cmp_seq | input | CMPL_W x SEQ_W | Sequence number of the completed entry |
| cmp_fault | input | CMPL_W | Completed entry faulted |
| sq_req | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Last surviving sequence number |
| sq_mispredict | input | 1 | Request came from a mispredict |
| sq_taken | input | 1 | Resolved branch direction |
| sq_next_pc | input | PC_W | Redirect PC |
| sq_mispred_pc | input | PC_W | PC of the mispredicted branch |
| ret_valid | output | COMMIT_W | Retire slot valid |
| ret_seq | output | COMMIT_W x SEQ_W | Retired sequence numbers, oldest in slot 0 |
| ret_trap | output | 1 | A faulting entry retires this cycle |
| bk_done_seq | output | SEQ_W | Done sequence number |
| bk_squash | output | 1 | One-cycle squash pulse |
| bk_squashing | output | 1 | Squash walk in progress |
| bk_mispredict | output | 1 | Forwarded mispredict flag |
| bk_taken | output | 1 | Forwarded taken flag |
| bk_next_pc | output | PC_W | Forwarded redirect PC |
| bk_mispred_pc | output | PC_W | Forwarded mispredict PC |
| bk_free | output | CNT_W | Free entries |
| bk_ns_valid | output | 1 | Non-speculative execute request |
| bk_ns_seq | output | SEQ_W | Sequence number of that request |
| commit_total | output | CTR_W | Running count of retired instructions |

## Verification
A squash request can arrive in the same cycle as a head entry that is ready to retire and a rename group that could be inserted. The bench sets up exactly that case: it marks the head complete one cycle ahead, then raises the squash together with two valid lanes. In that cycle both `ret_valid` and `ins_accept` must be low. Afterwards the held-back head must retire once the walk ends, and the free count must show that the lanes were never written. A completion mark is also sent during the walk, where it collides with the squash marking, and the entry it names must retire on the first cycle after the walk.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    RB_RUN  = 1'b0,
    RB_WALK = 1'b1
  } rb_state_e;

  typedef struct packed {
    logic valid;
    logic squashed;
    logic executed;
    logic nonspec;
    logic ready;
    logic fault;
  } rb_flags_t;

endpackage

// File: rtl/rob_lane_pack.sv
module rob_lane_pack #(
  parameter int LANES = 2,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]         lane_valid,
  input  logic [LANES-1:0]         lane_drop,
  output logic [LANES-1:0]         lane_keep,
  output logic [LANES-1:0][CW-1:0] lane_pos,
  output logic [CW-1:0]            keep_cnt
);
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int l = 0; l < LANES; l++) begin
      lane_keep[l] = lane_valid[l] & ~lane_drop[l];
      lane_pos[l]  = acc;
      acc          = acc + CW'(lane_keep[l]);
    end
    keep_cnt = acc;
  end
endmodule

// File: rtl/rob_retire_scan.sv
module rob_retire_scan
  import rob_pkg::*;
#(
  parameter int SCAN     = 4,
  parameter int COMMIT_W = 2,
  parameter int SEQ_W    = 8,
  localparam int SW = $clog2(SCAN + 1)
) (
  input  logic                           enable,
  input  rb_flags_t [SCAN-1:0]           win_flags,
  input  logic [SCAN-1:0][SEQ_W-1:0]     win_seq,
  output logic [SW-1:0]                  rem_cnt,
  output logic [COMMIT_W-1:0]            ret_valid,
  output logic [COMMIT_W-1:0][SEQ_W-1:0] ret_seq,
  output logic                           trap,
  output logic                           ns_hit,
  output logic [SW-1:0]                  ns_slot,
  output logic [SEQ_W-1:0]               ns_seq
);
  always_comb begin
    logic alive;
    int   ncom;
    int   nrem;
    alive     = enable;
    ncom      = 0;
    nrem      = 0;
    ret_valid = '0;
    ret_seq   = '0;
    trap      = 1'b0;
    ns_hit    = 1'b0;
    ns_slot   = '0;
    ns_seq    = '0;
    for (int i = 0; i < SCAN; i++) begin
      if (alive && win_flags[i].valid && win_flags[i].ready && ncom < COMMIT_W) begin
        if (win_flags[i].squashed) begin
          nrem = nrem + 1;
        end else if (!win_flags[i].executed) begin
          alive = 1'b0;
          if (win_flags[i].nonspec) begin
            ns_hit  = 1'b1;
            ns_slot = SW'(i);
            ns_seq  = win_seq[i];
          end
        end else begin
          ret_valid[ncom] = 1'b1;
          ret_seq[ncom]   = win_seq[i];
          nrem = nrem + 1;
          ncom = ncom + 1;
          if (win_flags[i].fault) begin
            trap  = 1'b1;
            alive = 1'b0;
          end
        end
      end else begin
        alive = 1'b0;
      end
    end
    rem_cnt = SW'(nrem);
  end
endmodule

// File: rtl/rob_squash_scan.sv
module rob_squash_scan #(
  parameter int SQUASH_W = 2,
  parameter int SEQ_W    = 8,
  parameter int LEFT_W   = 5,
  localparam int MW = $clog2(SQUASH_W + 1)
) (
  input  logic [LEFT_W-1:0]              left,
  input  logic [SQUASH_W-1:0][SEQ_W-1:0] cand_seq,
  input  logic [SEQ_W-1:0]               bound_seq,
  output logic [MW-1:0]                  mark_cnt,
  output logic                           finish
);
  always_comb begin
    logic             go;
    logic [SEQ_W-1:0] diff;
    int               m;
    go = 1'b1;
    m  = 0;
    for (int i = 0; i < SQUASH_W; i++) begin
      diff = cand_seq[i] - bound_seq;
      if (go && i < int'(left) && !diff[SEQ_W-1] && diff != '0) m = m + 1;
      else go = 1'b0;
    end
    mark_cnt = MW'(m);
    finish   = (m < SQUASH_W) || (m == int'(left));
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SEQ_W    = 8,
  parameter int PC_W     = 32,
  parameter int RENAME_W = 2,
  parameter int COMMIT_W = 2,
  parameter int CMPL_W   = 2,
  parameter int SQUASH_W = 2,
  parameter int CTR_W    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [RENAME_W-1:0]            ins_valid,
  input  logic [RENAME_W-1:0][SEQ_W-1:0] ins_seq,
  input  logic [RENAME_W-1:0]            ins_squashed,
  input  logic [RENAME_W-1:0]            ins_nonspec,
  output logic                           ins_accept,
  input  logic [CMPL_W-1:0]              cmp_valid,
  input  logic [CMPL_W-1:0][SEQ_W-1:0]   cmp_seq,
  input  logic [CMPL_W-1:0]              cmp_fault,
  input  logic                           sq_req,
  input  logic [SEQ_W-1:0]               sq_seq,
  input  logic                           sq_mispredict,
  input  logic                           sq_taken,
  input  logic [PC_W-1:0]                sq_next_pc,
  input  logic [PC_W-1:0]                sq_mispred_pc,
  output logic [COMMIT_W-1:0]            ret_valid,
  output logic [COMMIT_W-1:0][SEQ_W-1:0] ret_seq,
  output logic                           ret_trap,
  output logic [SEQ_W-1:0]               bk_done_seq,
  output logic                           bk_squash,
  output logic                           bk_squashing,
  output logic                           bk_mispredict,
  output logic                           bk_taken,
  output logic [PC_W-1:0]                bk_next_pc,
  output logic [PC_W-1:0]                bk_mispred_pc,
  output logic [CNT_W-1:0]               bk_free,
  output logic                           bk_ns_valid,
  output logic [SEQ_W-1:0]               bk_ns_seq,
  output logic [CTR_W-1:0]               commit_total
);
  // DEPTH must be a power of two: pointers wrap naturally.
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int SCAN_W  = 2 * COMMIT_W;
  localparam int SCAN_CW = $clog2(SCAN_W + 1);
  localparam int LANE_CW = $clog2(RENAME_W + 1);
  localparam int MARK_CW = $clog2(SQUASH_W + 1);

  rb_flags_t [DEPTH-1:0]        flags_q, flags_n;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q, seq_n;
  logic [IDX_W-1:0]             head_q, head_n, tail_q, tail_n, walk_ptr_q, walk_ptr_n;
  logic [CNT_W-1:0]             cnt_q, cnt_n, walk_left_q, walk_left_n;
  rb_state_e                    state_q, state_n;
  logic [SEQ_W-1:0]             sq_seq_q, done_q;
  logic                         pulse_q, mis_q, tkn_q;
  logic [PC_W-1:0]              npc_q, mpc_q;
  logic [CTR_W-1:0]             total_q, total_n;

  logic                         run_ok;
  logic [RENAME_W-1:0]          lane_keep;
  logic [RENAME_W-1:0][LANE_CW-1:0] lane_pos;
  logic [LANE_CW-1:0]           keep_cnt;
  rb_flags_t [SCAN_W-1:0]       win_flags;
  logic [SCAN_W-1:0][SEQ_W-1:0] win_seq;
  logic [SCAN_CW-1:0]           rem_cnt, ns_slot;
  logic                         ns_hit;
  logic [SQUASH_W-1:0][SEQ_W-1:0] walk_seq;
  logic [MARK_CW-1:0]           mark_cnt;
  logic                         walk_finish;

  assign run_ok     = (state_q == RB_RUN) && !sq_req;
  assign bk_free    = CNT_W'(DEPTH) - cnt_q;
  assign ins_accept = run_ok && (CNT_W'(keep_cnt) <= bk_free);

  // Views of the head window and of the walk window.
  always_comb begin
    for (int i = 0; i < SCAN_W; i++) begin
      win_flags[i] = flags_q[head_q + IDX_W'(i)];
      win_seq[i]   = seq_q[head_q + IDX_W'(i)];
    end
    for (int i = 0; i < SQUASH_W; i++) walk_seq[i] = seq_q[walk_ptr_q - IDX_W'(i)];
  end

  rob_lane_pack #(.LANES(RENAME_W)) u_pack (
    .lane_valid(ins_valid), .lane_drop(ins_squashed),
    .lane_keep(lane_keep), .lane_pos(lane_pos), .keep_cnt(keep_cnt));

  rob_retire_scan #(.SCAN(SCAN_W), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)) u_scan (
    .enable(run_ok), .win_flags(win_flags), .win_seq(win_seq),
    .rem_cnt(rem_cnt), .ret_valid(ret_valid), .ret_seq(ret_seq), .trap(ret_trap),
    .ns_hit(ns_hit), .ns_slot(ns_slot), .ns_seq(bk_ns_seq));

  rob_squash_scan #(.SQUASH_W(SQUASH_W), .SEQ_W(SEQ_W), .LEFT_W(CNT_W)) u_walk (
    .left(walk_left_q), .cand_seq(walk_seq), .bound_seq(sq_seq_q),
    .mark_cnt(mark_cnt), .finish(walk_finish));

  assign bk_ns_valid   = ns_hit;
  assign bk_squash     = pulse_q;
  assign bk_squashing  = (state_q == RB_WALK);
  assign bk_mispredict = mis_q;
  assign bk_taken      = tkn_q;
  assign bk_next_pc    = npc_q;
  assign bk_mispred_pc = mpc_q;
  assign commit_total  = total_q;

  always_comb begin
    if (state_q == RB_WALK) begin
      if (pulse_q || walk_left_q == '0) bk_done_seq = sq_seq_q;
      else                              bk_done_seq = seq_q[walk_ptr_q];
    end else begin
      bk_done_seq = done_q;
      for (int k = 0; k < COMMIT_W; k++) if (ret_valid[k]) bk_done_seq = ret_seq[k];
    end
  end

  // Next-state: retire, insert, walk, completion marks, squash entry.
  always_comb begin
    flags_n     = flags_q;
    seq_n       = seq_q;
    state_n     = state_q;
    walk_ptr_n  = walk_ptr_q;
    walk_left_n = walk_left_q;
    for (int i = 0; i < SCAN_W; i++)
      if (i < int'(rem_cnt)) flags_n[head_q + IDX_W'(i)] = '0;
    if (ns_hit) flags_n[head_q + IDX_W'(ns_slot)].ready = 1'b0;
    head_n = head_q + IDX_W'(rem_cnt);
    tail_n = tail_q;
    cnt_n  = cnt_q - CNT_W'(rem_cnt);
    if (ins_accept) begin
      for (int l = 0; l < RENAME_W; l++) begin
        if (lane_keep[l]) begin
          flags_n[tail_q + IDX_W'(lane_pos[l])] = '{valid: 1'b1, squashed: 1'b0,
            executed: 1'b0, nonspec: ins_nonspec[l], ready: ins_nonspec[l], fault: 1'b0};
          seq_n[tail_q + IDX_W'(lane_pos[l])] = ins_seq[l];
        end
      end
      tail_n = tail_q + IDX_W'(keep_cnt);
      cnt_n  = cnt_n + CNT_W'(keep_cnt);
    end
    if (state_q == RB_WALK) begin
      for (int i = 0; i < SQUASH_W; i++) begin
        if (i < int'(mark_cnt)) begin
          flags_n[walk_ptr_q - IDX_W'(i)].squashed = 1'b1;
          flags_n[walk_ptr_q - IDX_W'(i)].ready    = 1'b1;
        end
      end
      walk_ptr_n  = walk_ptr_q - IDX_W'(mark_cnt);
      walk_left_n = walk_left_q - CNT_W'(mark_cnt);
      if (walk_finish) state_n = RB_RUN;
    end
    for (int c = 0; c < CMPL_W; c++) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (cmp_valid[c] && flags_n[e].valid && seq_n[e] == cmp_seq[c]) begin
          flags_n[e].ready    = 1'b1;
          flags_n[e].executed = 1'b1;
          flags_n[e].fault    = flags_n[e].fault | cmp_fault[c];
        end
      end
    end
    if (sq_req) begin
      state_n     = RB_WALK;
      walk_ptr_n  = tail_q - IDX_W'(1);
      walk_left_n = cnt_q;
    end
    total_n = total_q + CTR_W'($countones(ret_valid));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q     <= '0;
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      state_q     <= RB_RUN;
      walk_ptr_q  <= '0;
      walk_left_q <= '0;
      pulse_q     <= 1'b0;
      done_q      <= '0;
      total_q     <= '0;
    end else begin
      flags_q     <= flags_n;
      head_q      <= head_n;
      tail_q      <= tail_n;
      cnt_q       <= cnt_n;
      state_q     <= state_n;
      walk_ptr_q  <= walk_ptr_n;
      walk_left_q <= walk_left_n;
      pulse_q     <= sq_req;
      done_q      <= bk_done_seq;
      total_q     <= total_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_seq_q <= '0;
      mis_q    <= 1'b0;
      tkn_q    <= 1'b0;
      npc_q    <= '0;
      mpc_q    <= '0;
    end else if (sq_req) begin
      sq_seq_q <= sq_seq;
      mis_q    <= sq_mispredict;
      tkn_q    <= sq_taken;
      npc_q    <= sq_next_pc;
      mpc_q    <= sq_mispred_pc;
    end
  end

  always_ff @(posedge clk) seq_q <= seq_n;

endmodule

// File: rtl/rob_retire_chk.sv
module rob_retire_chk #(
  parameter int DEPTH    = 16,
  parameter int SEQ_W    = 8,
  parameter int COMMIT_W = 2,
  parameter int CNT_W    = 5,
  parameter int CTR_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sq_req,
  input logic [SEQ_W-1:0]    sq_seq,
  input logic                ins_accept,
  input logic [COMMIT_W-1:0] ret_valid,
  input logic                ret_trap,
  input logic [SEQ_W-1:0]    bk_done_seq,
  input logic                bk_squash,
  input logic                bk_squashing,
  input logic                bk_ns_valid,
  input logic [CNT_W-1:0]    bk_free,
  input logic [CTR_W-1:0]    commit_total
);
  AST_NO_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != '0) |-> (bk_free != CNT_W'(DEPTH))); // R12
  AST_WALK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bk_squashing |-> (ret_valid == '0 && !ins_accept && !bk_ns_valid)); // R8
  AST_SQUASH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req |=> (bk_squash && bk_squashing && bk_done_seq == $past(sq_seq))); // R7
  AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    bk_squash |-> $past(sq_req)); // R7
  AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req |-> (ret_valid == '0 && !ins_accept)); // R7
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bk_free <= CNT_W'(DEPTH)); // R10
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_total == $past(commit_total) + CTR_W'($countones($past(ret_valid)))); // R12
  AST_TRAP_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_trap |-> (ret_valid != '0)); // R6
endmodule

bind rob_retire rob_retire_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .COMMIT_W(COMMIT_W), .CNT_W(CNT_W), .CTR_W(CTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sq_req(sq_req), .sq_seq(sq_seq),
  .ins_accept(ins_accept), .ret_valid(ret_valid), .ret_trap(ret_trap),
  .bk_done_seq(bk_done_seq), .bk_squash(bk_squash), .bk_squashing(bk_squashing),
  .bk_ns_valid(bk_ns_valid), .bk_free(bk_free), .commit_total(commit_total)
);

// File: tb/rob_retire_tb_top.sv
module rob_retire_tb_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int SEQ_W  = 8;
  localparam int PC_W   = 32;

  logic clk, rst_n;
  logic [1:0] ins_valid, ins_squashed, ins_nonspec;
  logic [1:0][SEQ_W-1:0] ins_seq;
  logic ins_accept;
  logic [1:0] cmp_valid, cmp_fault;
  logic [1:0][SEQ_W-1:0] cmp_seq;
  logic sq_req, sq_mispredict, sq_taken;
  logic [SEQ_W-1:0] sq_seq;
  logic [PC_W-1:0] sq_next_pc, sq_mispred_pc;
  logic [1:0] ret_valid;
  logic [1:0][SEQ_W-1:0] ret_seq;
  logic ret_trap, bk_squash, bk_squashing, bk_mispredict, bk_taken, bk_ns_valid;
  logic [SEQ_W-1:0] bk_done_seq, bk_ns_seq;
  logic [PC_W-1:0] bk_next_pc, bk_mispred_pc;
  logic [4:0] bk_free;
  logic [31:0] commit_total;

  int n_chk = 0;
  int n_fail = 0;

  rob_retire dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_squashed(ins_squashed),
    .ins_nonspec(ins_nonspec), .ins_accept(ins_accept),
    .cmp_valid(cmp_valid), .cmp_seq(cmp_seq), .cmp_fault(cmp_fault),
    .sq_req(sq_req), .sq_seq(sq_seq), .sq_mispredict(sq_mispredict), .sq_taken(sq_taken),
    .sq_next_pc(sq_next_pc), .sq_mispred_pc(sq_mispred_pc),
    .ret_valid(ret_valid), .ret_seq(ret_seq), .ret_trap(ret_trap),
    .bk_done_seq(bk_done_seq), .bk_squash(bk_squash), .bk_squashing(bk_squashing),
    .bk_mispredict(bk_mispredict), .bk_taken(bk_taken), .bk_next_pc(bk_next_pc),
    .bk_mispred_pc(bk_mispred_pc), .bk_free(bk_free), .bk_ns_valid(bk_ns_valid),
    .bk_ns_seq(bk_ns_seq), .commit_total(commit_total));

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    ins_valid = '0; ins_squashed = '0; ins_nonspec = '0; ins_seq = '0;
    cmp_valid = '0; cmp_fault = '0; cmp_seq = '0;
    sq_req = 1'b0; sq_seq = '0; sq_mispredict = 1'b0; sq_taken = 1'b0;
    sq_next_pc = '0; sq_mispred_pc = '0;
  endtask

  task automatic put(input logic v0, input int s0, input logic q0, input logic n0,
                     input logic v1, input int s1, input logic q1, input logic n1);
    ins_valid = {v1, v0}; ins_squashed = {q1, q0}; ins_nonspec = {n1, n0};
    ins_seq[0] = SEQ_W'(s0); ins_seq[1] = SEQ_W'(s1);
  endtask

  task automatic done2(input logic v0, input int s0, input logic f0,
                       input logic v1, input int s1, input logic f1);
    cmp_valid = {v1, v0}; cmp_fault = {f1, f0};
    cmp_seq[0] = SEQ_W'(s0); cmp_seq[1] = SEQ_W'(s1);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk("R1", "free", bk_free, DEPTH);
    chk("R1", "ret_valid", ret_valid, 0);
    chk("R1", "squashing", bk_squashing, 0);
    chk("R1", "total", commit_total, 0);
  endtask

  task automatic t_basic();
    put(1, 20, 0, 0, 1, 21, 0, 0); #1 chk("R2", "accept", ins_accept, 1); nxt();
    put(1, 22, 1, 0, 1, 23, 0, 0); #1 chk("R2", "accept squashed lane", ins_accept, 1); nxt();
    ins_valid = '0; #1;
    chk("R2", "free after dropped lane", bk_free, 13);
    chk("R3", "nothing ready", ret_valid, 0);
    done2(1, 21, 0, 0, 0, 0); nxt(); cmp_valid = '0; #1;
    chk("R3", "head not ready blocks", ret_valid, 0);
    done2(1, 20, 0, 1, 23, 0); nxt(); cmp_valid = '0; #1;
    chk("R3", "two retire", ret_valid, 3);
    chk("R3", "slot0 seq", ret_seq[0], 20);
    chk("R3", "slot1 seq", ret_seq[1], 21);
    chk("R11", "done seq", bk_done_seq, 21);
    nxt(); #1;
    chk("R3", "third retire", ret_valid, 1);
    chk("R3", "third seq", ret_seq[0], 23);
    nxt(); #1;
    chk("R10", "free drained", bk_free, DEPTH);
    chk("R11", "done held", bk_done_seq, 23);
    chk("R12", "total", commit_total, 3);
  endtask

  task automatic t_width();
    put(1, 30, 0, 0, 1, 31, 0, 0); nxt();
    put(1, 32, 0, 0, 1, 33, 0, 0); nxt(); ins_valid = '0;
    done2(1, 31, 0, 1, 32, 0); nxt(); cmp_valid = '0; #1;
    chk("R3", "stop at unready head", ret_valid, 0);
    done2(1, 30, 0, 1, 33, 0); nxt(); cmp_valid = '0; #1;
    chk("R3", "limit slots", ret_valid, 3);
    chk("R3", "limit seq1", ret_seq[1], 31);
    nxt(); #1;
    chk("R3", "rest retire", ret_valid, 3);
    chk("R3", "rest seq0", ret_seq[0], 32);
    nxt();
  endtask

  task automatic t_nonspec();
    put(1, 40, 0, 1, 1, 41, 0, 0); nxt(); ins_valid = '0; #1;
    chk("R5", "ns request", bk_ns_valid, 1);
    chk("R5", "ns seq", bk_ns_seq, 40);
    chk("R5", "no retire with ns", ret_valid, 0);
    done2(1, 41, 0, 0, 0, 0); nxt(); cmp_valid = '0; #1;
    chk("R5", "ns not repeated", bk_ns_valid, 0);
    chk("R5", "still stalled", ret_valid, 0);
    done2(1, 40, 0, 0, 0, 0); nxt(); cmp_valid = '0; #1;
    chk("R5", "ns retires", ret_valid, 3);
    chk("R5", "ns seq retired", ret_seq[0], 40);
    nxt();
  endtask

  task automatic t_fault();
    put(1, 50, 0, 0, 1, 51, 0, 0); nxt(); ins_valid = '0;
    done2(1, 50, 1, 1, 51, 0); nxt(); cmp_valid = '0; cmp_fault = '0; #1;
    chk("R6", "trap", ret_trap, 1);
    chk("R6", "stop after trap", ret_valid, 1);
    chk("R6", "trap seq", ret_seq[0], 50);
    nxt(); #1;
    chk("R6", "trap clear", ret_trap, 0);
    chk("R6", "next retires", ret_seq[0], 51);
    nxt();
  endtask

  task automatic t_squash();
    put(1, 254, 0, 0, 1, 255, 0, 0); nxt();
    put(1, 0, 0, 0, 1, 1, 0, 0); nxt();
    put(1, 2, 0, 0, 1, 3, 0, 0); nxt(); ins_valid = '0;
    done2(1, 254, 0, 0, 0, 0); nxt(); cmp_valid = '0;
    sq_req = 1'b1; sq_seq = 8'd255; sq_mispredict = 1'b1; sq_taken = 1'b0;
    sq_next_pc = 32'h0000_1000; sq_mispred_pc = 32'h0000_0ff0;
    put(1, 9, 0, 0, 1, 10, 0, 0); #1;
    chk("R7", "retire blocked by request", ret_valid, 0);
    chk("R7", "insert blocked by request", ins_accept, 0);
    nxt(); sq_req = 1'b0; done2(1, 255, 0, 0, 0, 0); #1;
    chk("R7", "pulse", bk_squash, 1);
    chk("R7", "squashing", bk_squashing, 1);
    chk("R7", "done seq", bk_done_seq, 255);
    chk("R7", "mispredict", bk_mispredict, 1);
    chk("R7", "taken", bk_taken, 0);
    chk("R7", "next pc", bk_next_pc, 32'h1000);
    chk("R7", "mispred pc", bk_mispred_pc, 32'h0ff0);
    chk("R8", "insert blocked in walk", ins_accept, 0);
    nxt(); cmp_valid = '0; #1;
    chk("R8", "pulse single", bk_squash, 0);
    chk("R8", "walk cycle 2", bk_squashing, 1);
    chk("R8", "walk position seq", bk_done_seq, 1);
    chk("R8", "no retire in walk", ret_valid, 0);
    nxt(); #1;
    chk("R8", "walk cycle 3", bk_squashing, 1);
    ins_valid = '0;
    nxt(); #1;
    chk("R8", "walk ended", bk_squashing, 0);
    chk("R9", "marked during walk retires", ret_valid, 3);
    chk("R9", "slot1 seq", ret_seq[1], 255);
    nxt(); #1;
    chk("R4", "squashed leave silently", ret_valid, 0);
    nxt(); #1;
    chk("R4", "free after silent removal", bk_free, DEPTH);
  endtask

  task automatic t_full();
    for (int k = 0; k < 7; k++) begin
      put(1, 60 + 2 * k, 0, 0, 1, 61 + 2 * k, 0, 0); nxt();
    end
    ins_valid = '0; #1;
    chk("R10", "free two", bk_free, 2);
    put(1, 74, 0, 0, 1, 90, 1, 0); #1 chk("R2", "one kept fits", ins_accept, 1); nxt();
    put(1, 75, 0, 0, 1, 76, 0, 0); #1 chk("R2", "two do not fit", ins_accept, 0);
    put(1, 75, 0, 0, 1, 91, 1, 0); #1 chk("R2", "one fits last slot", ins_accept, 1); nxt();
    ins_valid = '0; #1 chk("R10", "full", bk_free, 0);
    put(1, 76, 0, 0, 0, 0, 0, 0); #1 chk("R2", "full rejects", ins_accept, 0);
    ins_valid = '0;
    for (int k = 0; k < 8; k++) begin
      done2(1, 60 + 2 * k, 0, 1, 61 + 2 * k, 0); nxt();
    end
    cmp_valid = '0;
    nxt(); nxt(); #1;
    chk("R10", "drained", bk_free, DEPTH);
    chk("R12", "grand total", commit_total, 29);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    t_reset();
    t_basic();
    t_width();
    t_nonspec();
    t_fault();
    t_squash();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule